// File: doc/BRIEF.md
# Pointer-Redirect Register Port

This block sits between a processor's data-memory port and its register file. It turns one reserved data address into a window: the reserved address has no storage of its own. Any access to it is steered to the register whose address a pointer register holds. A bank bit, taken from the processor's status register, is placed above the 8-bit pointer to form a 9-bit register-file address. The pointer register lives inside the block and also has a direct address of its own, so software loads it and steps it with ordinary register writes. Status-flag generation and the register-file storage are outside the block.

Both sides use a valid/ready handshake, and a transfer completes in the cycle where valid and ready are both high. A forwarded access shows the request on the register-file side in the same cycle, and `cpu_ready` follows `rf_ready`, so register-file back-pressure reaches the processor without any buffering. Accesses the block handles itself complete at once: pointer reads and writes, and every access through the window while the pointer selects the window itself. A read returns its data combinationally in the completing cycle. A write takes effect at the clock edge that ends that cycle. The requester must hold address, write enable and write data stable while valid is high and ready is low.

Top module: `ind_addr_port`

## Requirements
- R1: After reset the pointer register holds 00h, so a read of the pointer address (04h) returns 00h.
- R2: A valid access to any address other than the window (00h) and the pointer address (04h) appears on the register-file side in the same cycle. Its 9-bit address is the 8-bit address with a 0 above it, and its write enable and write data are unchanged. A read returns `rf_rdata`.
- R3: An access to address 04h reads or writes the pointer register. It completes in the cycle it is presented (`cpu_ready` = 1) and never asserts `rf_valid`. A written value is visible from the next cycle.
- R4: An access to address 00h with a pointer value P other than 00h and 04h goes to the register-file address {bank, P}, where bank is the bank input and occupies bit 8.
- R5: A read of 00h while the pointer holds 00h returns 00h, completes at once, and leaves `rf_valid` low.
- R6: A write to 00h while the pointer holds 00h stores nothing: `rf_valid` stays low and the pointer keeps its value.
- R7: With parameter BANK_EN = 0, bit 8 of every register-file address is 0, whatever the bank input is.
- R8: `rf_valid` is high only while `cpu_valid` is high. For a forwarded access `cpu_ready` equals `rf_ready`, so a stalled register file holds the processor.
- R9: An access to 00h while the pointer holds 04h reaches the pointer register itself (read returns the pointer, write replaces it), whatever the bank input is, and leaves `rf_valid` low.
- R10: Stepping the pointer from 20h and clearing through the window until pointer bit 4 is set zeroes registers 20h to 2Fh and leaves 1Fh and 30h unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_addr | input | 8 | Processor data address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid when the read completes |
| bank | input | 1 | Bank bit from the status register |
| rf_valid | output | 1 | Register-file request valid |
| rf_ready | input | 1 | Register file accepts the request |
| rf_addr | output | 9 | Register-file address |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data |

## Verification
The assertions check on every cycle that self-referencing window accesses and pointer accesses never reach the register file and complete at once. They also check that the pointer changes only under a write strobe, that the register-file request never runs ahead of the processor request, and that the window address carries the correct bank bit. Only the scenarios can show end-to-end data values: the pointer-stepped read of two neighbouring registers, the clearing loop stopping on pointer bit 4, the stalled transfers that finish with correct data, and the dropped write leaving the register file untouched.

// File: rtl/ind_port_pkg.sv
package ind_port_pkg;
  typedef enum logic [1:0] {
    ROUTE_FWD  = 2'd0,
    ROUTE_NULL = 2'd1,
    ROUTE_PTR  = 2'd2
  } route_e;
endpackage

// File: rtl/ind_route_dec.sv
module ind_route_dec
  import ind_port_pkg::*;
#(
  parameter int W        = 8,
  parameter int IND_ADDR = 0,
  parameter int PTR_ADDR = 4
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] ptr,
  output route_e       route,
  output logic         is_ind
);
  localparam logic [W-1:0] IND_A = W'(IND_ADDR);
  localparam logic [W-1:0] PTR_A = W'(PTR_ADDR);

  always_comb begin
    is_ind = (addr == IND_A);
    route  = ROUTE_FWD;
    if (is_ind) begin
      if (ptr == IND_A)      route = ROUTE_NULL;
      else if (ptr == PTR_A) route = ROUTE_PTR;
    end else if (addr == PTR_A) begin
      route = ROUTE_PTR;
    end
  end
endmodule

// File: rtl/ind_ptr_reg.sv
module ind_ptr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata;
  end

  // R3/R6: pointer moves only on its write strobe
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
  assert_ptr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wdata));
endmodule

// File: rtl/ind_link_mux.sv
module ind_link_mux
  import ind_port_pkg::*;
#(
  parameter int W       = 8,
  parameter bit BANK_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  route_e       route,
  input  logic         is_ind,
  input  logic [W-1:0] ptr,
  input  logic         bank,
  input  logic         cpu_valid,
  input  logic [W-1:0] cpu_addr,
  input  logic         cpu_we,
  input  logic [W-1:0] cpu_wdata,
  output logic         cpu_ready,
  output logic [W-1:0] cpu_rdata,
  output logic         ptr_wr,
  output logic         rf_valid,
  output logic [W:0]   rf_addr,
  output logic         rf_we,
  output logic [W-1:0] rf_wdata,
  input  logic         rf_ready,
  input  logic [W-1:0] rf_rdata
);
  logic hi_bit;

  generate
    if (BANK_EN) begin : g_bank
      assign hi_bit = bank;
    end else begin : g_nobank
      assign hi_bit = 1'b0;
    end
  endgenerate

  always_comb begin
    rf_valid  = 1'b0;
    rf_we     = 1'b0;
    rf_wdata  = cpu_wdata;
    rf_addr   = is_ind ? {hi_bit, ptr} : {1'b0, cpu_addr};
    cpu_ready = 1'b1;
    cpu_rdata = '0;
    ptr_wr    = 1'b0;
    unique case (route)
      ROUTE_FWD: begin
        rf_valid  = cpu_valid;
        rf_we     = cpu_we;
        cpu_ready = rf_ready;
        cpu_rdata = rf_rdata;
      end
      ROUTE_PTR: begin
        cpu_rdata = ptr;
        ptr_wr    = cpu_valid & cpu_we;
      end
      default: begin
        cpu_rdata = '0;
      end
    endcase
  end

  // R8: no register-file request without a processor request
  assert_rf_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid |-> cpu_valid);
  // R5/R6: self-reference never reaches the register file
  assert_null_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && route == ROUTE_NULL) |-> (!rf_valid && cpu_ready && cpu_rdata == '0));
  // R7: bank bit in the window address
  assert_bank_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && is_ind) |-> (rf_addr[W] == (BANK_EN ? bank : 1'b0)));
endmodule

// File: rtl/ind_addr_port.sv
module ind_addr_port
  import ind_port_pkg::*;
#(
  parameter int W        = 8,
  parameter int IND_ADDR = 0,
  parameter int PTR_ADDR = 4,
  parameter bit BANK_EN  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_valid,
  output logic         cpu_ready,
  input  logic [7:0]   cpu_addr,
  input  logic         cpu_we,
  input  logic [7:0]   cpu_wdata,
  output logic [7:0]   cpu_rdata,
  input  logic         bank,
  output logic         rf_valid,
  input  logic         rf_ready,
  output logic [8:0]   rf_addr,
  output logic         rf_we,
  output logic [7:0]   rf_wdata,
  input  logic [7:0]   rf_rdata
);
  localparam int EW = W + 1;
  localparam logic [W-1:0] IND_A = W'(IND_ADDR);
  localparam logic [W-1:0] PTR_A = W'(PTR_ADDR);

  route_e         route;
  logic           is_ind;
  logic           ptr_wr;
  logic [W-1:0]   ptr_q;
  logic [EW-1:0]  rf_addr_w;

  ind_route_dec #(.W(W), .IND_ADDR(IND_ADDR), .PTR_ADDR(PTR_ADDR)) u_dec (
    .addr  (cpu_addr),
    .ptr   (ptr_q),
    .route (route),
    .is_ind(is_ind)
  );

  ind_ptr_reg #(.W(W)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(ptr_wr),
    .wdata(cpu_wdata),
    .q    (ptr_q)
  );

  ind_link_mux #(.W(W), .BANK_EN(BANK_EN)) u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .route    (route),
    .is_ind   (is_ind),
    .ptr      (ptr_q),
    .bank     (bank),
    .cpu_valid(cpu_valid),
    .cpu_addr (cpu_addr),
    .cpu_we   (cpu_we),
    .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata),
    .ptr_wr   (ptr_wr),
    .rf_valid (rf_valid),
    .rf_addr  (rf_addr_w),
    .rf_we    (rf_we),
    .rf_wdata (rf_wdata),
    .rf_ready (rf_ready),
    .rf_rdata (rf_rdata)
  );

  assign rf_addr = rf_addr_w;

  // R2: plain addresses pass straight through
  assert_direct_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_addr != IND_A && cpu_addr != PTR_A) |->
      (rf_valid && rf_addr == {1'b0, cpu_addr} && rf_we == cpu_we && cpu_ready == rf_ready));
  // R3: pointer address is served locally
  assert_ptr_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_addr == PTR_A) |-> (cpu_ready && !rf_valid));
  // R9: window aimed at the pointer reaches the pointer
  assert_self_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_addr == IND_A && ptr_q == PTR_A) |-> (!rf_valid && cpu_rdata == PTR_A));
endmodule

// File: tb/sim_ind_addr_port.sv
`timescale 1ns/1ps
module sim_ind_addr_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_valid = 1'b0;
  logic       cpu_ready;
  logic [7:0] cpu_addr = 8'h00;
  logic       cpu_we = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       bank = 1'b0;
  logic       rf_valid;
  logic       rf_ready;
  logic [8:0] rf_addr;
  logic       rf_we;
  logic [7:0] rf_wdata;
  logic [7:0] rf_rdata;
  logic       u1_ready, u1_valid, u1_we;
  logic [7:0] u1_rdata, u1_wdata;
  logic [8:0] u1_addr;
  logic       stall_on = 1'b0;
  logic [1:0] cyc;
  logic [7:0] mem [0:511];
  int total = 0;
  int bad = 0;
  logic [7:0] expq [$];
  string      tagq [$];

  always #10 clk = ~clk;

  ind_addr_port u0 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bank(bank), .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_addr(rf_addr),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata));

  ind_addr_port #(.BANK_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(u1_ready),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(u1_rdata),
    .bank(bank), .rf_valid(u1_valid), .rf_ready(rf_ready), .rf_addr(u1_addr),
    .rf_we(u1_we), .rf_wdata(u1_wdata), .rf_rdata(rf_rdata));

  function automatic logic [7:0] init_val(input int i);
    if (i == 5) return 8'h10;
    if (i == 6) return 8'h0A;
    if (i == 9'h106) return 8'h3C;
    if (i >= 8'h1F && i <= 8'h30) return 8'hAA;
    return 8'hEE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 2'd1;
  end
  assign rf_ready = stall_on ? cyc[1] : 1'b1;
  assign rf_rdata = mem[rf_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= init_val(i);
    end else if (rf_valid && rf_ready && rf_we) begin
      mem[rf_addr] <= rf_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as reads complete
  always @(negedge clk) begin
    if (rst_n && cpu_valid && cpu_ready && !cpu_we) begin
      if (expq.size() == 0) begin
        chk(1'b0, "scoreboard-empty", cpu_rdata, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(cpu_rdata == e, t, cpu_rdata, e);
      end
    end
  end

  // driver: one transfer; local_exp = served inside the block
  task automatic xfer(input logic [7:0] a, input logic we, input logic [7:0] wd,
                      input logic local_exp, input logic [8:0] exp_addr,
                      input logic [7:0] exp_rd, input string tag);
    bit done;
    if (!we) begin
      expq.push_back(exp_rd);
      tagq.push_back(tag);
    end
    cpu_addr  = a;
    cpu_we    = we;
    cpu_wdata = wd;
    cpu_valid = 1'b1;
    done = 1'b0;
    while (!done) begin
      @(negedge clk);
      if (local_exp) begin
        chk(!rf_valid && cpu_ready, tag, {rf_valid, cpu_ready}, 2'b01);
      end else begin
        chk(rf_valid && rf_addr == exp_addr && rf_we == we && cpu_ready == rf_ready,
            tag, rf_addr, exp_addr);
        chk(u1_addr == {1'b0, exp_addr[7:0]}, "R7", u1_addr, {1'b0, exp_addr[7:0]});
      end
      done = cpu_ready;
      @(posedge clk);
      #2;
    end
    cpu_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] p;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;

    // R1 reset value of the pointer
    xfer(8'h04, 1'b0, 8'h00, 1'b1, 9'h000, 8'h00, "R1");
    // R5 self-reference read, R6 dropped write
    xfer(8'h00, 1'b0, 8'h00, 1'b1, 9'h000, 8'h00, "R5");
    xfer(8'h00, 1'b1, 8'h55, 1'b1, 9'h000, 8'h00, "R6");
    xfer(8'h04, 1'b0, 8'h00, 1'b1, 9'h000, 8'h00, "R6");
    @(negedge clk);
    chk(mem[0] == 8'hEE && mem[9'h100] == 8'hEE, "R6", mem[0], 8'hEE);
    @(posedge clk); #2;

    // R3 pointer load; R4 worked case
    xfer(8'h04, 1'b1, 8'h05, 1'b1, 9'h000, 8'h00, "R3");
    xfer(8'h04, 1'b0, 8'h00, 1'b1, 9'h000, 8'h05, "R3");
    xfer(8'h00, 1'b0, 8'h00, 1'b0, 9'h005, 8'h10, "R4");
    xfer(8'h04, 1'b1, 8'h06, 1'b1, 9'h000, 8'h00, "R3");
    xfer(8'h00, 1'b0, 8'h00, 1'b0, 9'h006, 8'h0A, "R4");
    bank = 1'b1;
    xfer(8'h00, 1'b0, 8'h00, 1'b0, 9'h106, 8'h3C, "R4");

    // R9 window aimed at the pointer itself
    xfer(8'h04, 1'b1, 8'h04, 1'b1, 9'h000, 8'h00, "R3");
    xfer(8'h00, 1'b0, 8'h00, 1'b1, 9'h000, 8'h04, "R9");
    xfer(8'h00, 1'b1, 8'h07, 1'b1, 9'h000, 8'h00, "R9");
    xfer(8'h04, 1'b0, 8'h00, 1'b1, 9'h000, 8'h07, "R9");
    bank = 1'b0;

    // R2 direct pass; R8 with back-pressure
    xfer(8'h05, 1'b0, 8'h00, 1'b0, 9'h005, 8'h10, "R2");
    stall_on = 1'b1;
    xfer(8'h40, 1'b1, 8'h99, 1'b0, 9'h040, 8'h00, "R8");
    xfer(8'h40, 1'b0, 8'h00, 1'b0, 9'h040, 8'h99, "R8");
    @(negedge clk);
    chk(!rf_valid, "R8", rf_valid, 0);
    @(posedge clk); #2;

    // R10 clearing loop through the window
    p = 8'h20;
    xfer(8'h04, 1'b1, p, 1'b1, 9'h000, 8'h00, "R10");
    while (p[4] == 1'b0 || p == 8'h20) begin
      xfer(8'h00, 1'b1, 8'h00, 1'b0, {1'b0, p}, 8'h00, "R10");
      xfer(8'h04, 1'b0, 8'h00, 1'b1, 9'h000, p, "R10");
      p = p + 8'h01;
      xfer(8'h04, 1'b1, p, 1'b1, 9'h000, 8'h00, "R10");
      if (p[4]) break;
    end
    stall_on = 1'b0;
    xfer(8'h1F, 1'b0, 8'h00, 1'b0, 9'h01F, 8'hAA, "R10");
    for (int i = 8'h20; i <= 8'h2F; i++)
      xfer(8'(i), 1'b0, 8'h00, 1'b0, {1'b0, 8'(i)}, 8'h00, "R10");
    xfer(8'h30, 1'b0, 8'h00, 1'b0, 9'h030, 8'hAA, "R10");

    repeat (2) @(posedge clk);
    chk(expq.size() == 0, "scoreboard-drain", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule